// File: doc/BRIEF.md
# AHB Transfer Trace Recorder

This block sits beside an AHB bus as a passive observer and keeps a log of the bus transfers that carry data. In each cycle where HREADY is high it looks at the address-phase signals. A NONSEQ or SEQ transfer is held in a pipeline register until its data phase completes. The block then forms one 128-bit record from the held address-phase fields, the data word, the response code and a cycle timestamp, and writes it into an internal trace memory.

Capture runs only while the external trigger enable is high. A one-cycle arm pulse restarts the log: it clears the write pointer, the status flags and the timestamp counter. A mode input chooses between two behaviours. In stop mode the recorder halts once every slot holds a record. In circular mode it overwrites the oldest records and raises a sticky flag. A bus slave wrapper outside this block reads the memory through a synchronous read port, and it reads the write pointer and both flags directly.

Top module: `ahb_trace_recorder`

## Requirements
- R1: A record is produced only for address phases accepted with HREADY=1 and HTRANS equal to NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) and BUSY (2'b01) never produce a record.
- R2: A record is written in the cycle where the transfer's data phase completes with HREADY=1. Wait states delay the write. The data field takes HWDATA for a write and HRDATA for a read.
- R3: Record layout: [31:0] address, [63:32] data, [95:64] timestamp, [99:96] master, [101:100] transfer type, [104:102] burst, [107:105] size, [109:108] response, [110] write, [111] lock, [127:112] zero.
- R4: The timestamp counter increments every cycle and reads 0 in the cycle after an arm pulse. A record holds the counter value of its completion cycle.
- R5: A record is written only in completion cycles where capture_en=1. In every other cycle wr_ptr holds its value.
- R6: Stop mode (wrap_mode=0): writing the last slot (DEPTH-1) sets full and returns wr_ptr to 0. While full is set, no record is written until the next arm.
- R7: Circular mode (wrap_mode=1): writing the last slot returns wr_ptr to 0 and sets the sticky wrapped flag. full stays 0 and later records overwrite the oldest slots.
- R8: A two-cycle ERROR, RETRY or SPLIT response produces exactly one record, written on the final (HREADY=1) cycle and carrying that response code.
- R9: An arm pulse clears wr_ptr, full and wrapped by the next cycle. No record is written in the arm cycle.
- R10: A read with rd_en=1 returns the stored record for rd_addr on rd_data one cycle later. rd_data holds its value while rd_en=0. A read and a write to the same slot in one cycle return the old contents.
- R11: During reset, wr_ptr, full, wrapped and rd_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | Trigger-driven capture enable |
| arm | input | 1 | One-cycle pulse that restarts the log |
| wrap_mode | input | 1 | 1 = circular overwrite, 0 = stop when full |
| haddr | input | 32 | Monitored address |
| htrans | input | 2 | Monitored transfer type |
| hwrite | input | 1 | Monitored direction |
| hsize | input | 3 | Monitored transfer size |
| hburst | input | 3 | Monitored burst type |
| hmaster | input | 4 | Monitored master number |
| hmastlock | input | 1 | Monitored locked-transfer indicator |
| hready | input | 1 | Monitored transfer-done signal |
| hresp | input | 2 | Monitored slave response |
| hwdata | input | 32 | Monitored write data |
| hrdata | input | 32 | Monitored read data |
| rd_en | input | 1 | Trace memory read strobe |
| rd_addr | input | AW | Trace memory read slot |
| rd_data | output | 128 | Record returned one cycle after rd_en |
| wr_ptr | output | AW | Next slot to be written |
| full | output | 1 | Stop-mode buffer full |
| wrapped | output | 1 | Circular-mode rollover has occurred |

## Verification
On every cycle the assertions check the pointer and flag rules: writes happen only under the trigger and never when full or armed, the pointer steps by one slot or not at all, the flags stay sticky, and an arm clears them. The cycle-by-cycle model in the bench is the only thing that shows the record contents. That covers transfer filtering, pairing each address with its own data across wait states and pipelined overlap, timestamp values, the single record for a two-cycle error response, and read-before-write on the memory port.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int REC_W  = 128;
  localparam int BUS_AW = 32;
  localparam int BUS_DW = 32;
  localparam int TS_W   = 32;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  typedef struct packed {
    logic [BUS_AW-1:0] addr;
    logic [3:0]        master;
    logic [1:0]        trans;
    logic [2:0]        burst;
    logic [2:0]        size;
    logic              write;
    logic              lock;
  } addr_phase_t;

  function automatic logic [REC_W-1:0] pack_record(
    input addr_phase_t     ap,
    input logic [BUS_DW-1:0] data,
    input logic [TS_W-1:0]   ts,
    input logic [1:0]        resp
  );
    logic [REC_W-1:0] r;
    r           = '0;
    r[31:0]     = ap.addr;
    r[63:32]    = data;
    r[95:64]    = ts;
    r[99:96]    = ap.master;
    r[101:100]  = ap.trans;
    r[104:102]  = ap.burst;
    r[107:105]  = ap.size;
    r[109:108]  = resp;
    r[110]      = ap.write;
    r[111]      = ap.lock;
    return r;
  endfunction
endpackage

// File: rtl/trace_addr_stage.sv
module trace_addr_stage
  import trace_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hready,
  input  logic [1:0]        htrans,
  input  logic [BUS_AW-1:0] haddr,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [2:0]        hburst,
  input  logic [3:0]        hmaster,
  input  logic              hmastlock,
  output addr_phase_t       ap_q,
  output logic              pend_q
);
  logic        take;
  logic        pend_d;
  addr_phase_t ap_d;

  // NONSEQ and SEQ both have bit 1 set
  assign take = hready && htrans[1];

  always_comb begin
    pend_d = pend_q;
    ap_d   = ap_q;
    if (hready) begin
      pend_d = htrans[1];
    end
    if (take) begin
      ap_d.addr   = haddr;
      ap_d.master = hmaster;
      ap_d.trans  = htrans;
      ap_d.burst  = hburst;
      ap_d.size   = hsize;
      ap_d.write  = hwrite;
      ap_d.lock   = hmastlock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ap_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (take) begin
        ap_q <= ap_d;
      end
    end
  end
endmodule

// File: rtl/trace_buf_ctrl.sv
module trace_buf_ctrl
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            wrap_mode,
  input  logic            req,
  output logic            we,
  output logic [AW-1:0]   wptr,
  output logic            full,
  output logic            wrapped,
  output logic [TS_W-1:0] ts
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0]   wptr_d;
  logic            full_d;
  logic            wrapped_d;
  logic [TS_W-1:0] ts_d;

  assign we = req && !full && !arm;

  always_comb begin
    wptr_d    = wptr;
    full_d    = full;
    wrapped_d = wrapped;
    ts_d      = ts + 1'b1;
    if (arm) begin
      wptr_d    = '0;
      full_d    = 1'b0;
      wrapped_d = 1'b0;
      ts_d      = '0;
    end else if (we) begin
      if (wptr == LAST) begin
        wptr_d = '0;
        if (wrap_mode) begin
          wrapped_d = 1'b1;
        end else begin
          full_d = 1'b1;
        end
      end else begin
        wptr_d = wptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      full    <= 1'b0;
      wrapped <= 1'b0;
      ts      <= '0;
    end else begin
      wptr    <= wptr_d;
      full    <= full_d;
      wrapped <= wrapped_d;
      ts      <= ts_d;
    end
  end
endmodule

// File: rtl/trace_mem.sv
module trace_mem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= store[raddr];
    end
  end
endmodule

// File: rtl/ahb_trace_recorder.sv
module ahb_trace_recorder
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_en,
  input  logic             arm,
  input  logic             wrap_mode,
  input  logic [31:0]      haddr,
  input  logic [1:0]       htrans,
  input  logic             hwrite,
  input  logic [2:0]       hsize,
  input  logic [2:0]       hburst,
  input  logic [3:0]       hmaster,
  input  logic             hmastlock,
  input  logic             hready,
  input  logic [1:0]       hresp,
  input  logic [31:0]      hwdata,
  input  logic [31:0]      hrdata,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [127:0]     rd_data,
  output logic [AW-1:0]    wr_ptr,
  output logic             full,
  output logic             wrapped
);
  addr_phase_t      ap_q;
  logic             pend_q;
  logic             rec_req;
  logic             rec_we;
  logic [TS_W-1:0]  ts;
  logic [BUS_DW-1:0] dsel;
  logic [REC_W-1:0] rec;

  trace_addr_stage u_addr (
    .clk(clk), .rst_n(rst_n), .hready(hready), .htrans(htrans),
    .haddr(haddr), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .hmaster(hmaster), .hmastlock(hmastlock),
    .ap_q(ap_q), .pend_q(pend_q)
  );

  assign rec_req = pend_q && hready && capture_en;
  assign dsel    = ap_q.write ? hwdata : hrdata;
  assign rec     = pack_record(ap_q, dsel, ts, hresp);

  trace_buf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .wrap_mode(wrap_mode),
    .req(rec_req), .we(rec_we), .wptr(wr_ptr), .full(full),
    .wrapped(wrapped), .ts(ts)
  );

  trace_mem #(.DEPTH(DEPTH), .WIDTH(REC_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(rec_we), .waddr(wr_ptr), .wdata(rec),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/ahb_trace_recorder_chk.sv
module ahb_trace_recorder_chk #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          capture_en,
  input logic          hready,
  input logic          rec_we,
  input logic [AW-1:0] wr_ptr,
  input logic          full,
  input logic          wrapped
);
  // R5
  we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_we |-> (capture_en && hready && !full && !arm));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_we && !arm) |=> $stable(wr_ptr));

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !arm) |=> full);

  // R7
  wrapped_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !arm) |=> wrapped);

  // R9
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (wr_ptr == '0 && !full && !wrapped));

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_we |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1) || wr_ptr == '0));
endmodule

bind ahb_trace_recorder ahb_trace_recorder_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .capture_en(capture_en),
  .hready(hready), .rec_we(rec_we), .wr_ptr(wr_ptr), .full(full),
  .wrapped(wrapped)
);

// File: tb/tb_ahb_trace_recorder.sv
module tb_ahb_trace_recorder;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic capture_en, arm, wrap_mode;
  logic [31:0] haddr, hwdata, hrdata;
  logic [1:0] htrans, hresp;
  logic hwrite, hmastlock, hready;
  logic [2:0] hsize, hburst;
  logic [3:0] hmaster;
  logic rd_en;
  logic [AW-1:0] rd_addr;
  logic [127:0] rd_data;
  logic [AW-1:0] wr_ptr;
  logic full, wrapped;

  always #5 clk = ~clk;

  ahb_trace_recorder #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .arm(arm),
    .wrap_mode(wrap_mode), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hburst(hburst), .hmaster(hmaster), .hmastlock(hmastlock),
    .hready(hready), .hresp(hresp), .hwdata(hwdata), .hrdata(hrdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_ptr(wr_ptr), .full(full), .wrapped(wrapped)
  );

  int nvec = 0;
  int nerr = 0;
  bit done = 0;
  string cur_req = "R10";

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [127:0] m_mem [int];
  int           m_ptr;
  bit           m_full, m_wrap, m_pend, m_rd_known;
  int unsigned  m_ts;
  logic [127:0] m_rd;
  logic [31:0]  a_addr;
  logic [3:0]   a_master;
  logic [1:0]   a_trans;
  logic [2:0]   a_burst, a_size;
  logic         a_write, a_lock;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_full = 0; m_wrap = 0; m_pend = 0; m_ts = 0;
      m_rd = '0; m_rd_known = 1;
    end else begin
      logic [127:0] e;
      if (rd_en) begin
        if (m_mem.exists(int'(rd_addr))) begin
          m_rd = m_mem[int'(rd_addr)];
          m_rd_known = 1;
        end else begin
          m_rd_known = 0;
        end
      end
      if (m_pend && hready && capture_en && !m_full && !arm) begin
        e = '0;
        e[31:0] = a_addr;
        e[63:32] = a_write ? hwdata : hrdata;
        e[95:64] = m_ts;
        e[99:96] = a_master;
        e[101:100] = a_trans;
        e[104:102] = a_burst;
        e[107:105] = a_size;
        e[109:108] = hresp;
        e[110] = a_write;
        e[111] = a_lock;
        m_mem[m_ptr] = e;
        if (m_ptr == DEPTH - 1) begin
          m_ptr = 0;
          if (wrap_mode) m_wrap = 1; else m_full = 1;
        end else begin
          m_ptr++;
        end
      end
      if (arm) begin
        m_ptr = 0; m_full = 0; m_wrap = 0; m_ts = 0;
      end else begin
        m_ts++;
      end
      if (hready) begin
        m_pend = (htrans == 2'b10 || htrans == 2'b11);
        if (m_pend) begin
          a_addr = haddr; a_master = hmaster; a_trans = htrans;
          a_burst = hburst; a_size = hsize; a_write = hwrite; a_lock = hmastlock;
        end
      end
    end
  end

  // Compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 wr_ptr", 128'(wr_ptr), 128'(m_ptr[AW-1:0]));
      chk("R6 full", 128'(full), 128'(m_full));
      chk("R7 wrapped", 128'(wrapped), 128'(m_wrap));
      if (m_rd_known) chk({cur_req, " rd_data"}, rd_data, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk);
  endtask

  task automatic bus_idle();
    htrans = 2'b00; hready = 1'b1; hresp = 2'b00; arm = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rand_traffic(int n, bit with_arm, bit with_reads);
    for (int i = 0; i < n; i++) begin
      htrans    = 2'($urandom_range(0, 3));
      haddr     = $urandom;
      hwrite    = 1'($urandom);
      hsize     = 3'($urandom);
      hburst    = 3'($urandom);
      hmaster   = 4'($urandom);
      hmastlock = 1'($urandom);
      hready    = ($urandom_range(0, 4) != 0);
      hwdata    = $urandom;
      hrdata    = $urandom;
      hresp     = 2'b00;
      arm       = with_arm && ($urandom_range(0, 49) == 0);
      rd_en     = with_reads && 1'($urandom);
      rd_addr   = AW'($urandom_range(0, DEPTH - 1));
      step();
    end
    bus_idle();
    step();
  endtask

  task automatic read_all();
    for (int i = 0; i < DEPTH; i++) begin
      rd_en = 1'b1; rd_addr = AW'(i);
      step();
    end
    rd_en = 1'b0;
    step();
  endtask

  task automatic read_slot(int s);
    rd_en = 1'b1; rd_addr = AW'(s);
    step();
    rd_en = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [AW-1:0] p0;
    rst_n = 1'b0; capture_en = 1'b0; wrap_mode = 1'b0;
    haddr = '0; hwdata = '0; hrdata = '0; hwrite = 0; hsize = 0; hburst = 0;
    hmaster = 0; hmastlock = 0; rd_addr = '0;
    bus_idle();
    step(); step();
    // R11 reset values
    chk("R11 wr_ptr", 128'(wr_ptr), 128'(0));
    chk("R11 full", 128'(full), 128'(0));
    chk("R11 wrapped", 128'(wrapped), 128'(0));
    chk("R11 rd_data", rd_data, 128'(0));
    rst_n = 1'b1;
    step();

    // R3 R4 R2: two hand-built transfers with known timestamps
    cur_req = "R3";
    capture_en = 1'b1;
    arm = 1'b1; step(); arm = 1'b0;
    htrans = 2'b10; haddr = 32'h1000_0040; hwrite = 1; hsize = 3'd2;
    hburst = 3'd1; hmaster = 4'h5; hmastlock = 0; hready = 1;
    step();
    htrans = 2'b10; haddr = 32'h2000_0000; hwrite = 0; hsize = 3'd0;
    hburst = 3'd0; hmaster = 4'h3; hmastlock = 1; hwdata = 32'hDEAD_BEEF;
    step();
    htrans = 2'b00; hready = 0; hrdata = 32'h1111_1111;
    step();
    hready = 1; hrdata = 32'h0000_00A5;
    step();
    bus_idle(); step();
    read_slot(0);
    chk("R3 addr", 128'(rd_data[31:0]), 128'(32'h1000_0040));
    chk("R2 write data", 128'(rd_data[63:32]), 128'(32'hDEAD_BEEF));
    chk("R4 timestamp", 128'(rd_data[95:64]), 128'(1));
    chk("R3 ctrl", 128'(rd_data[111:96]), 128'({1'b0, 1'b1, 2'b00, 3'd2, 3'd1, 2'b10, 4'h5}));
    chk("R3 zero", 128'(rd_data[127:112]), 128'(0));
    read_slot(1);
    chk("R2 read data after wait", 128'(rd_data[63:32]), 128'(32'h0000_00A5));
    chk("R4 timestamp after wait", 128'(rd_data[95:64]), 128'(3));
    chk("R3 lock", 128'(rd_data[111]), 128'(1));

    // R1: IDLE and BUSY only, no entries
    cur_req = "R1";
    p0 = wr_ptr;
    for (int i = 0; i < 20; i++) begin
      htrans = 2'(i % 2); haddr = $urandom; hready = 1; step();
    end
    bus_idle(); step();
    chk("R1 idle busy no entry", 128'(wr_ptr), 128'(p0));

    // R5: trigger low, traffic ignored
    cur_req = "R5";
    capture_en = 1'b0;
    rand_traffic(60, 0, 0);
    chk("R5 ptr unchanged", 128'(wr_ptr), 128'(p0));
    capture_en = 1'b1;

    // R8: two-cycle error response gives one entry
    cur_req = "R8";
    p0 = wr_ptr;
    htrans = 2'b10; haddr = 32'hE000_0010; hwrite = 1; hready = 1; step();
    htrans = 2'b00; hready = 0; hresp = 2'b01; step();
    hready = 1; hresp = 2'b01; hwdata = 32'hBAD0_0001; step();
    bus_idle(); step();
    chk("R8 one entry", 128'(wr_ptr), 128'(AW'(p0 + 1'b1)));
    read_slot(int'(p0));
    chk("R8 resp field", 128'(rd_data[109:108]), 128'(2'b01));

    // R6: stop when full
    cur_req = "R6";
    wrap_mode = 1'b0;
    arm = 1'b1; step(); arm = 1'b0;
    rand_traffic(500, 0, 1);
    chk("R6 full set", 128'(full), 128'(1));
    chk("R6 ptr at zero", 128'(wr_ptr), 128'(0));
    read_all();

    // R7: circular overwrite
    cur_req = "R7";
    wrap_mode = 1'b1;
    arm = 1'b1; step(); arm = 1'b0;
    rand_traffic(500, 0, 1);
    chk("R7 wrapped set", 128'(wrapped), 128'(1));
    chk("R7 full clear", 128'(full), 128'(0));
    read_all();

    // R9 R10: arm pulses and reads mixed into traffic
    cur_req = "R9";
    rand_traffic(1500, 1, 1);
    arm = 1'b1; step(); arm = 1'b0;
    chk("R9 arm clears ptr", 128'(wr_ptr), 128'(0));
    chk("R9 arm clears wrapped", 128'(wrapped), 128'(0));
    cur_req = "R10";
    wrap_mode = 1'b0;
    rand_traffic(800, 0, 1);
    read_all();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule